// File: doc/BRIEF.md
# Packet Serial Transmitter with Queued Frame Counts

This block is an asynchronous serial transmitter that sends whole packets instead of single bytes. Software packs payload bytes into 32-bit words, lowest byte lane first, and writes them into a word FIFO. It then pushes each packet's byte count into a separate count FIFO. Every count that reaches the head of that FIFO starts one packet. The serializer sends exactly that many bytes and then holds the line idle for a programmable number of bit times before it takes the next count. Several packets can therefore be queued and sent as one burst.

The block also drives the enable input of an external half-duplex line driver. The enable can be held on by software. It can also be raised automatically for each packet, a programmable number of clocks before the first start bit, and dropped after the last stop bit. The bit rate comes from a 20-bit phase accumulator: the rate word is added to the accumulator on every clock, and each carry out marks a bit boundary. A combined mode/status word holds the configuration and reports queue depth, activity and a sticky error for an overfilled count FIFO. One special value written to that word empties both FIFOs and stops any packet in progress.

Top module: `pkt_uart_tx`

## Requirements
- R1: A bit lasts 2^20 / RATE clocks when RATE divides 2^20, where RATE is the value written at register address 2. Bytes within one packet follow each other with no idle time, so consecutive start bits are 10 bit times apart. A RATE of zero produces no bit boundaries.
- R2: The line idles high. Each byte is sent as one low start bit, eight data bits least significant first, and one high stop bit.
- R3: A word written at address 0 holds bytes in lanes [7:0], [15:8], [23:16] and [31:24], sent in that order. A packet's last word may hold 1 to 3 valid bytes in its low lanes, and the next packet starts on a fresh word.
- R4: A write at address 1 queues a byte count (bits [9:0]) in a 16-entry FIFO. Mode/status bits [20:16] report the number of counts waiting. A count written while that FIFO is full is dropped and sets sticky error bit 4.
- R5: After a packet's last stop bit, the line stays idle for at least G and fewer than G+2 bit times before the next packet, where G is mode bits [15:8].
- R6: With auto-enable (mode bit 5) set, drv_en rises at least L clocks before each packet's first start bit, where L is mode bits [3:0]. It stays high while any start or data bit is on the line and is low again once the packet and its gap are done.
- R7: With force-enable (mode bit 6) set, drv_en is high on every cycle. With neither bit 5 nor bit 6 set, drv_en stays low.
- R8: Writing exactly 32'h8001_0000 at address 3 is a clear command. It aborts the packet in progress, returns the line to idle high, empties both FIFOs and clears error bit 4. It leaves the configuration unchanged, and nothing that was queued is sent afterwards.
- R9: Reading address 3 returns: bit 21 set while the word FIFO holds data, bits [20:16] the number of queued counts, bits [15:8] the gap, bit 7 set while a packet is being processed, bit 6 force, bit 5 auto, bit 4 error, bits [3:0] the lead time. Reading address 0 returns the word FIFO fill level, and address 2 returns RATE.
- R10: A queued count of zero is consumed and sends nothing.
- R11: If a packet still has bytes to send but the word FIFO is empty, the line stays idle high and bit 7 stays set until a word arrives. Transmission then continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 word FIFO, 1 count FIFO, 2 rate, 3 mode |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| txd | output | 1 | Serial output, idle high |
| drv_en | output | 1 | External line driver enable |

## Verification
On every cycle, the assertions check that the line is high whenever no packet is being processed, and that a start or data bit never appears in auto-enable mode without drv_en. They also check the lead time at each start bit, the forced enable, the bound on queued counts, the setting and holding of the overflow error, and the empty state right after a clear. The bench scenarios are the only check on the actual byte values and lane order, the bit period at two rates, the spacing between packets, the consumption of zero counts, the stall on a missing data word, and the fact that nothing queued before a clear is ever sent.

// File: rtl/pkt_uart_pkg.sv
package pkt_uart_pkg;

  localparam logic [1:0]  ADDR_DATA  = 2'd0;
  localparam logic [1:0]  ADDR_COUNT = 2'd1;
  localparam logic [1:0]  ADDR_RATE  = 2'd2;
  localparam logic [1:0]  ADDR_MODE  = 2'd3;
  localparam logic [31:0] CLEAR_WORD = 32'h8001_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SYNC, ST_START, ST_DATA, ST_STOP, ST_GAP
  } tx_state_e;

  typedef struct packed {
    logic [7:0] gap_bits;
    logic       force_de;
    logic       auto_de;
    logic [3:0] lead_clks;
  } tx_cfg_t;

  // byte lane select, lane 0 is sent first
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic tx_cfg_t cfg_from_word(input logic [31:0] w);
    tx_cfg_t c;
    c.gap_bits  = w[15:8];
    c.force_de  = w[6];
    c.auto_de   = w[5];
    c.lead_clks = w[3:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_status(input logic data_ne, input logic [4:0] frames,
                                              input tx_cfg_t c, input logic busy, input logic err);
    return {10'd0, data_ne, frames, c.gap_bits, busy, c.force_de, c.auto_de, err, c.lead_clks};
  endfunction

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign level   = wr_ptr - rd_ptr;
  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= din;
  end
endmodule

// File: rtl/pkt_baud_gen.sv
module pkt_baud_gen #(
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] rate,
  output logic             tick
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, rate};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= sum[ACC_W-1:0];
      tick <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/pkt_tx_engine.sv
module pkt_tx_engine
  import pkt_uart_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             tick,
  input  tx_cfg_t          cfg,
  input  logic             cnt_empty,
  input  logic [CNT_W-1:0] cnt_head,
  output logic             cnt_pop,
  input  logic             data_empty,
  input  logic [31:0]      data_head,
  output logic             data_pop,
  output logic             txd,
  output logic             drv_en,
  output logic             active,
  output logic             start_evt
);
  tx_state_e        state;
  logic [CNT_W-1:0] bytes_left;
  logic [1:0]       lane;
  logic [7:0]       shreg;
  logic [2:0]       bit_idx;
  logic [7:0]       timer;
  logic             more_bytes, byte_fetch, last_lane;

  assign more_bytes = (bytes_left != '0);
  assign byte_fetch = !flush && tick && !data_empty &&
                      ((state == ST_SYNC) || (state == ST_STOP && more_bytes));
  assign last_lane  = (lane == 2'd3) || (bytes_left == CNT_W'(1));
  assign data_pop   = byte_fetch && last_lane;
  assign cnt_pop    = !flush && (state == ST_IDLE) && !cnt_empty;
  assign start_evt  = byte_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bytes_left <= '0;
      lane       <= '0;
      shreg      <= '1;
      bit_idx    <= '0;
      timer      <= '0;
    end else if (flush) begin
      state      <= ST_IDLE;
      bytes_left <= '0;
      lane       <= '0;
      shreg      <= '1;
      bit_idx    <= '0;
      timer      <= '0;
    end else begin
      if (byte_fetch) begin
        shreg      <= lane_byte(data_head, lane);
        lane       <= last_lane ? 2'd0 : lane + 2'd1;
        bytes_left <= bytes_left - 1'b1;
        bit_idx    <= '0;
      end
      case (state)
        ST_IDLE: begin
          if (cnt_pop && cnt_head != '0) begin
            bytes_left <= cnt_head;
            timer      <= 8'(cfg.lead_clks);
            state      <= cfg.auto_de ? ST_LEAD : ST_SYNC;
          end
        end
        ST_LEAD: begin
          if (timer == '0) state <= ST_SYNC;
          else             timer <= timer - 1'b1;
        end
        ST_SYNC: begin
          if (byte_fetch) state <= ST_START;
        end
        ST_START: begin
          if (tick) state <= ST_DATA;
        end
        ST_DATA: begin
          if (tick) begin
            if (bit_idx == 3'd7) begin
              state <= ST_STOP;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= {1'b1, shreg[7:1]};
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (more_bytes)                state <= byte_fetch ? ST_START : ST_SYNC;
            else if (cfg.gap_bits == '0)   state <= ST_IDLE;
            else begin
              state <= ST_GAP;
              timer <= cfg.gap_bits;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (timer <= 8'd1) state <= ST_IDLE;
            else               timer <= timer - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      default:  txd = 1'b1;
    endcase
  end

  assign active = (state != ST_IDLE);
  assign drv_en = cfg.force_de ||
                  (cfg.auto_de && (state inside {ST_LEAD, ST_SYNC, ST_START, ST_DATA, ST_STOP}));
endmodule

// File: rtl/pkt_uart_tx.sv
module pkt_uart_tx
  import pkt_uart_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int CNT_DEPTH  = 16,
  parameter int CNT_W      = 10,
  parameter int ACC_W      = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        txd,
  output logic        drv_en
);
  localparam int DLW = $clog2(DATA_DEPTH) + 1;
  localparam int CLW = $clog2(CNT_DEPTH) + 1;

  tx_cfg_t          cfg_q;
  logic [ACC_W-1:0] rate_q;
  logic             cnt_err;
  logic             tick;

  logic             clear_cmd, cfg_wr, data_push, cnt_push;
  logic             data_empty, data_full, data_pop;
  logic [31:0]      data_head;
  logic [DLW-1:0]   data_level;
  logic             cnt_empty, cnt_full, cnt_pop;
  logic [CNT_W-1:0] cnt_head;
  logic [CLW-1:0]   cnt_level;
  logic             tx_active, start_evt;
  logic             cfg_auto, cfg_force;
  logic [3:0]       cfg_lead;
  logic [31:0]      status_word;

  assign clear_cmd = wr_en && (wr_addr == ADDR_MODE) && (wr_data == CLEAR_WORD);
  assign cfg_wr    = wr_en && (wr_addr == ADDR_MODE) && !clear_cmd;
  assign data_push = wr_en && (wr_addr == ADDR_DATA) && !data_full;
  assign cnt_push  = wr_en && (wr_addr == ADDR_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rate_q  <= '0;
      cnt_err <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_from_word(wr_data);
      if (wr_en && wr_addr == ADDR_RATE) rate_q <= wr_data[ACC_W-1:0];
      if (clear_cmd)                 cnt_err <= 1'b0;
      else if (cnt_push && cnt_full) cnt_err <= 1'b1;
    end
  end

  pkt_fifo #(.WIDTH(32), .DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clear_cmd),
    .push(data_push), .din(wr_data), .pop(data_pop),
    .dout(data_head), .empty(data_empty), .full(data_full), .level(data_level)
  );

  pkt_fifo #(.WIDTH(CNT_W), .DEPTH(CNT_DEPTH)) u_cnt_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clear_cmd),
    .push(cnt_push), .din(wr_data[CNT_W-1:0]), .pop(cnt_pop),
    .dout(cnt_head), .empty(cnt_empty), .full(cnt_full), .level(cnt_level)
  );

  pkt_baud_gen #(.ACC_W(ACC_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .rate(rate_q), .tick(tick)
  );

  pkt_tx_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .flush(clear_cmd), .tick(tick), .cfg(cfg_q),
    .cnt_empty(cnt_empty), .cnt_head(cnt_head), .cnt_pop(cnt_pop),
    .data_empty(data_empty), .data_head(data_head), .data_pop(data_pop),
    .txd(txd), .drv_en(drv_en), .active(tx_active), .start_evt(start_evt)
  );

  assign cfg_auto    = cfg_q.auto_de;
  assign cfg_force   = cfg_q.force_de;
  assign cfg_lead    = cfg_q.lead_clks;
  assign status_word = pack_status(!data_empty, 5'(cnt_level), cfg_q, tx_active, cnt_err);

  always_comb begin
    case (rd_addr)
      ADDR_DATA: rd_data = 32'(data_level);
      ADDR_RATE: rd_data = 32'(rate_q);
      ADDR_MODE: rd_data = status_word;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pkt_uart_tx_chk.sv
module pkt_uart_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        txd,
  input logic        drv_en,
  input logic        tx_active,
  input logic        start_evt,
  input logic        clear_cmd,
  input logic        cnt_push,
  input logic        cnt_full,
  input logic [31:0] status,
  input logic        cfg_auto,
  input logic        cfg_force,
  input logic [3:0]  cfg_lead
);
  logic [7:0] de_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                de_age <= '0;
    else if (!drv_en)          de_age <= '0;
    else if (de_age != 8'hff)  de_age <= de_age + 1'b1;
  end

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> txd);

  p_frames_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[20:16] <= 5'd16);

  p_err_on_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_push && cnt_full && !clear_cmd) |=> status[4]);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !clear_cmd) |=> status[4]);

  p_lead_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cfg_auto && !cfg_force) |-> (de_age >= 8'(cfg_lead)));

  p_de_covers_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto && !txd) |-> drv_en);

  p_forced_de_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force |-> drv_en);

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cmd |=> (status[21:16] == 6'd0 && !status[7] && !status[4] && txd));
endmodule

bind pkt_uart_tx pkt_uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .drv_en(drv_en),
  .tx_active(tx_active), .start_evt(start_evt), .clear_cmd(clear_cmd),
  .cnt_push(cnt_push), .cnt_full(cnt_full), .status(status_word),
  .cfg_auto(cfg_auto), .cfg_force(cfg_force), .cfg_lead(cfg_lead)
);

// File: tb/pkt_uart_tx_test.sv
module pkt_uart_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd3;
  logic [31:0] rd_data;
  logic        txd, drv_en;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int bit_clks = 4;
  int rx_cnt = 0;
  int frame_errs = 0;
  logic [7:0] rx_byte [256];
  int rx_start [256];
  int de_rise = 0;
  int chk_de = 0;
  int de_miss = 0;

  pkt_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .txd(txd), .drv_en(drv_en)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // serial line decoder
  initial begin : line_mon
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin : one_frame
        int st;
        logic [7:0] b;
        st = cyc;
        repeat (bit_clks / 2) @(negedge clk);
        if (txd) frame_errs++;
        for (int k = 0; k < 8; k++) begin
          repeat (bit_clks) @(negedge clk);
          b[k] = txd;
        end
        repeat (bit_clks) @(negedge clk);
        if (!txd) frame_errs++;
        if (rx_cnt < 256) begin
          rx_byte[rx_cnt]  = b;
          rx_start[rx_cnt] = st;
        end
        rx_cnt++;
      end
      prev = txd;
    end
  end

  // driver-enable observer
  initial begin : de_mon
    logic dprev;
    dprev = 1'b0;
    forever begin
      @(negedge clk);
      if (drv_en && !dprev) de_rise = cyc;
      if (chk_de != 0 && !txd && !drv_en) de_miss++;
      dprev = drv_en;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog (all requirements): actual %0d cycles, expected completion earlier", cyc);
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 5000; n++) begin
      rd(2'd3, s);
      if (!s[7] && s[20:16] == 5'd0) break;
    end
    repeat (bit_clks * 3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(2'd3, s);
    check(s == 32'd0, "R9", "status after reset", s, 0);
    check(txd == 1'b1, "R2", "line idle after reset", txd, 1);
    check(drv_en == 1'b0, "R7", "drv_en after reset", drv_en, 0);
    rd(2'd2, s);
    check(s == 32'd0, "R1", "rate after reset", s, 0);
  endtask

  task automatic t_single();
    int base;
    logic [31:0] s;
    logic [7:0] exp_b [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    base = rx_cnt;
    bit_clks = 4;
    wr(2'd2, 32'h0004_0000);
    wr(2'd3, 32'h0000_0000);
    wr(2'd0, 32'h4433_2211);
    wr(2'd0, 32'h0000_0055);
    rd(2'd0, s);
    check(s == 32'd2, "R9", "word FIFO level", s, 2);
    rd(2'd3, s);
    check(s[21] == 1'b1, "R9", "data-present bit", s[21], 1);
    wr(2'd1, 32'd5);
    wait_idle();
    check(rx_cnt - base == 5, "R3", "bytes in 5-byte packet", rx_cnt - base, 5);
    for (int i = 0; i < 5; i++)
      check(rx_byte[base + i] == exp_b[i], "R3", "byte lane order", rx_byte[base + i], exp_b[i]);
    check(frame_errs == 0, "R2", "start/stop framing", frame_errs, 0);
    check(rx_start[base + 1] - rx_start[base] == 40, "R1", "start spacing at 4 clk/bit",
          rx_start[base + 1] - rx_start[base], 40);
  endtask

  task automatic t_rate8();
    int base;
    base = rx_cnt;
    bit_clks = 8;
    wr(2'd2, 32'h0002_0000);
    wr(2'd0, 32'h0000_6996);
    wr(2'd1, 32'd2);
    wait_idle();
    check(rx_cnt - base == 2, "R1", "bytes at 8 clk/bit", rx_cnt - base, 2);
    check(rx_byte[base] == 8'h96, "R1", "first byte at 8 clk/bit", rx_byte[base], 8'h96);
    check(rx_byte[base + 1] == 8'h69, "R2", "second byte at 8 clk/bit", rx_byte[base + 1], 8'h69);
    check(rx_start[base + 1] - rx_start[base] == 80, "R1", "start spacing at 8 clk/bit",
          rx_start[base + 1] - rx_start[base], 80);
    check(frame_errs == 0, "R2", "framing at 8 clk/bit", frame_errs, 0);
    bit_clks = 4;
    wr(2'd2, 32'h0004_0000);
  endtask

  task automatic t_burst();
    int base, sp;
    logic [7:0] exp_b [5] = '{8'hA1, 8'hA2, 8'hA3, 8'hB1, 8'hB2};
    base = rx_cnt;
    wr(2'd3, 32'h0000_0300);
    wr(2'd0, 32'h00A3_A2A1);
    wr(2'd0, 32'h0000_B2B1);
    wr(2'd1, 32'd3);
    wr(2'd1, 32'd2);
    wait_idle();
    check(rx_cnt - base == 5, "R3", "bytes over two packets", rx_cnt - base, 5);
    for (int i = 0; i < 5; i++)
      check(rx_byte[base + i] == exp_b[i], "R3", "partial word then fresh word", rx_byte[base + i], exp_b[i]);
    sp = rx_start[base + 3] - rx_start[base + 2];
    check(sp >= 13 * 4 && sp < 15 * 4, "R5", "packet spacing with gap 3", sp, 13 * 4);
  endtask

  task automatic t_auto();
    int base;
    base = rx_cnt;
    de_miss = 0;
    wr(2'd3, 32'h0000_0229);
    chk_de = 1;
    wr(2'd0, 32'h0000_BEEF);
    wr(2'd1, 32'd2);
    wait_idle();
    chk_de = 0;
    check(rx_cnt - base == 2, "R6", "bytes in auto mode", rx_cnt - base, 2);
    check(rx_byte[base] == 8'hEF && rx_byte[base + 1] == 8'hBE, "R6", "payload in auto mode",
          {rx_byte[base + 1], rx_byte[base]}, 16'hBEEF);
    check(rx_start[base] - de_rise >= 9, "R6", "lead clocks before start", rx_start[base] - de_rise, 9);
    check(de_miss == 0, "R6", "line bits without drv_en", de_miss, 0);
    check(drv_en == 1'b0, "R6", "drv_en after packet", drv_en, 0);
  endtask

  task automatic t_force();
    int base;
    base = rx_cnt;
    wr(2'd3, 32'h0000_0040);
    check(drv_en == 1'b1, "R7", "forced drv_en while idle", drv_en, 1);
    wr(2'd0, 32'h0000_003C);
    wr(2'd1, 32'd1);
    wait_idle();
    check(rx_byte[base] == 8'h3C, "R7", "byte with forced drv_en", rx_byte[base], 8'h3C);
    check(drv_en == 1'b1, "R7", "forced drv_en after packet", drv_en, 1);
    wr(2'd3, 32'h0000_0000);
    check(drv_en == 1'b0, "R7", "drv_en with neither mode", drv_en, 0);
  endtask

  task automatic t_zero();
    int base;
    logic [31:0] s;
    base = rx_cnt;
    wr(2'd1, 32'd0);
    repeat (100) @(negedge clk);
    rd(2'd3, s);
    check(s[20:16] == 5'd0 && !s[7], "R10", "zero count consumed", s[20:16], 0);
    check(rx_cnt == base, "R10", "nothing sent for zero count", rx_cnt - base, 0);
    wr(2'd0, 32'h0000_005A);
    wr(2'd1, 32'd1);
    wait_idle();
    check(rx_cnt - base == 1 && rx_byte[base] == 8'h5A, "R10", "next packet after zero count",
          rx_byte[base], 8'h5A);
  endtask

  task automatic t_wait_data();
    int base;
    logic [31:0] s;
    base = rx_cnt;
    wr(2'd1, 32'd2);
    repeat (100) @(negedge clk);
    rd(2'd3, s);
    check(s[7] == 1'b1, "R11", "busy while waiting for data", s[7], 1);
    check(txd == 1'b1 && rx_cnt == base, "R11", "line idle while waiting", rx_cnt - base, 0);
    wr(2'd0, 32'h0000_C3B2);
    wait_idle();
    check(rx_cnt - base == 2, "R11", "bytes after late data", rx_cnt - base, 2);
    check(rx_byte[base] == 8'hB2 && rx_byte[base + 1] == 8'hC3, "R11", "late data payload",
          {rx_byte[base + 1], rx_byte[base]}, 16'hC3B2);
  endtask

  task automatic t_queue_clear();
    int base;
    logic [31:0] s;
    base = rx_cnt;
    wr(2'd2, 32'd0);
    wr(2'd3, 32'h0000_0500);
    wr(2'd1, 32'd1);
    repeat (3) @(negedge clk);
    rd(2'd3, s);
    check(s[20:16] == 5'd0 && s[7], "R9", "first count taken, busy set", s[20:16], 0);
    wr(2'd0, 32'h0000_0011);
    rd(2'd3, s);
    check(s[21] == 1'b1, "R9", "data bit with stalled rate", s[21], 1);
    for (int i = 0; i < 16; i++) wr(2'd1, 32'd1);
    rd(2'd3, s);
    check(s[20:16] == 5'd16, "R4", "16 counts queued", s[20:16], 16);
    check(s[4] == 1'b0, "R4", "no error at exactly full", s[4], 0);
    wr(2'd1, 32'd1);
    rd(2'd3, s);
    check(s[4] == 1'b1, "R4", "error on push while full", s[4], 1);
    check(s[20:16] == 5'd16, "R4", "extra count dropped", s[20:16], 16);
    wr(2'd3, 32'h8001_0000);
    rd(2'd3, s);
    check(s[21:16] == 6'd0 && !s[7] && !s[4], "R8", "status after clear", s[21:4], 0);
    check(s[15:8] == 8'h05, "R8", "gap kept across clear", s[15:8], 5);
    wr(2'd2, 32'h0004_0000);
    repeat (400) @(negedge clk);
    check(rx_cnt == base, "R8", "nothing sent after clear", rx_cnt - base, 0);
    wr(2'd3, 32'h0000_0000);
  endtask

  task automatic t_abort();
    int base;
    logic [31:0] s;
    base = rx_cnt;
    wr(2'd0, 32'h4433_2211);
    wr(2'd0, 32'h8877_6655);
    wr(2'd1, 32'd8);
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (rx_cnt >= base + 2) break;
    end
    wr(2'd3, 32'h8001_0000);
    repeat (2) @(negedge clk);
    rd(2'd3, s);
    check(txd == 1'b1 && !s[7], "R8", "line idle after mid-packet clear", s[7], 0);
    check(s[21] == 1'b0, "R8", "word FIFO empty after clear", s[21], 0);
    repeat (400) @(negedge clk);
    check(rx_cnt - base <= 3, "R8", "packet aborted", rx_cnt - base, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_rate8();
    t_burst();
    t_auto();
    t_force();
    t_zero();
    t_wait_data();
    t_queue_clear();
    t_abort();
    summary();
    $finish;
  end
endmodule